// File: doc/BRIEF.md
# Hybrid Prefix-Tree Binary Adder

This block adds two unsigned words and a carry-in in a single combinational pass. Bitwise propagate and generate terms come first. A hybrid prefix tree then resolves every carry. The last step forms the sum bits and the carry-out. The tree first pairs each odd bit with the even bit below it. A logarithmic doubling network then runs over the odd positions only. A single closing step finishes the even positions from their odd neighbours. Compared with a full doubling network, this costs one extra level of logic and needs roughly half the long wires.

The carry-in is merged into the generate term of bit 0 before the tree starts. Every prefix that reaches down to bit 0 therefore already includes it. The word width is a power-of-two parameter. The block has no registers and drops into any datapath that needs a fast adder with a carry chain.

Top module: `hc_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin` for every input combination.
- R2: `cout` equals bit WIDTH of `a + b + cin`, the carry out of the most significant position.
- R3: With `a` all ones, `b` zero and `cin` = 1, the carry crosses the whole word: `sum` is zero and `cout` is 1.
- R4: With `a`, `b` and `cin` all zero, `sum` and `cout` are zero.
- R5: With `a` and `b` both all ones and `cin` = 1, `sum` is all ones and `cout` is 1.
- R6: When `b` is the bitwise complement of `a`, every bit only propagates: `cout` equals `cin`, and `sum` is all ones for `cin` = 0 and zero for `cin` = 1.
- R7: A single generate at bit k (`a` = `b` = 1<<k, `cin` = 0) gives `sum` = 1<<(k+1) for k < WIDTH-1 and `cout` = 1 for k = WIDTH-1. This holds at every odd and every even position.
- R8: WIDTH must be a power of two no smaller than 4, and any other value is rejected at elaboration. The result is correct at WIDTH = 8 over all input combinations and at the default WIDTH = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench goes after the long carry chain (all ones plus a carry-in) and after isolated generates at each bit position. A tree that skipped the closing even-position step would give wrong even carries in the isolated-generate test. A doubling network with a wrong span would drop carries that travel a long distance. Pure-propagate words expose a carry-in that was never folded into bit 0, which would show up as a `cout` that ignores `cin`. An exhaustive 8-bit sweep and random 16-bit words catch any mistake in a merge operator or in an index.

// File: rtl/hc_pkg.sv
package hc_pkg;

   typedef struct packed {
      logic p;
      logic g;
   } hc_pg_t;

   // Merge an upper span with the adjacent lower span.
   function automatic hc_pg_t hc_merge(input hc_pg_t hi, input hc_pg_t lo);
      hc_pg_t r;
      r.p = hi.p & lo.p;
      r.g = hi.g | (hi.p & lo.g);
      return r;
   endfunction

endpackage

// File: rtl/hc_prep.sv
module hc_prep
   import hc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   input  logic               cin,
   output hc_pg_t [WIDTH-1:0] bit_pg,
   output hc_pg_t [WIDTH-1:0] seed_pg
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_pg[i].p = a[i] ^ b[i];
      assign bit_pg[i].g = a[i] & b[i];
      if (i == 0) begin : g_fold
         // Carry-in acts as a generate below bit 0.
         assign seed_pg[i].p = bit_pg[i].p;
         assign seed_pg[i].g = bit_pg[i].g | (bit_pg[i].p & cin);
      end else begin : g_pass
         assign seed_pg[i] = bit_pg[i];
      end
   end

endmodule

// File: rtl/hc_tree.sv
module hc_tree
   import hc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  hc_pg_t [WIDTH-1:0] leaf,
   output hc_pg_t [WIDTH-1:0] pref
);

   localparam int LOGW   = $clog2(WIDTH);
   localparam int KS_LVL = LOGW - 1;

   hc_pg_t [WIDTH-1:0] stage [KS_LVL+1];

   // Opening pair step: odd bit absorbs the even bit below it.
   for (genvar i = 0; i < WIDTH; i++) begin : g_open
      if (i % 2 == 1) begin : g_odd
         assign stage[0][i] = hc_merge(leaf[i], leaf[i-1]);
      end else begin : g_even
         assign stage[0][i] = leaf[i];
      end
   end

   // Doubling network over odd positions, spans 2,4,...,WIDTH/2.
   for (genvar l = 1; l <= KS_LVL; l++) begin : g_lvl
      localparam int DIST = 1 << l;
      for (genvar i = 0; i < WIDTH; i++) begin : g_node
         if ((i % 2 == 1) && (i >= DIST + 1)) begin : g_mrg
            assign stage[l][i] = hc_merge(stage[l-1][i], stage[l-1][i-DIST]);
         end else begin : g_cpy
            assign stage[l][i] = stage[l-1][i];
         end
      end
   end

   // Closing step: even positions take the finished odd prefix below.
   for (genvar i = 0; i < WIDTH; i++) begin : g_close
      if ((i % 2 == 0) && (i > 0)) begin : g_fill
         assign pref[i] = hc_merge(leaf[i], stage[KS_LVL][i-1]);
      end else begin : g_keep
         assign pref[i] = stage[KS_LVL][i];
      end
   end

   // Group propagate of each prefix must be the AND of all leaf propagates.
   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         logic acc;
         acc = 1'b1;
         for (int j = 0; j <= i; j++) acc = acc & leaf[j].p;
         a_r7_prefix_propagate: assert (pref[i].p == acc)
            else $error("prefix propagate wrong at %0d", i);
      end
   end

   // No generate anywhere in the leaves means no generate in any prefix.
   always_comb begin
      logic any_g;
      any_g = 1'b0;
      for (int j = 0; j < WIDTH; j++) any_g = any_g | leaf[j].g;
      for (int i = 0; i < WIDTH; i++) begin
         a_r4_no_spurious_generate: assert (any_g || !pref[i].g)
            else $error("spurious generate at %0d", i);
      end
   end

endmodule

// File: rtl/hc_post.sv
module hc_post
   import hc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  hc_pg_t [WIDTH-1:0] bit_pg,
   input  hc_pg_t [WIDTH-1:0] pref,
   input  logic               cin,
   output logic [WIDTH-1:0]   sum,
   output logic               cout
);

   logic [WIDTH-1:0] carry_in;
   logic [WIDTH-1:0] prop;

   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign prop[i] = bit_pg[i].p;
      if (i == 0) begin : g_lsb
         assign carry_in[i] = cin;
      end else begin : g_up
         assign carry_in[i] = pref[i-1].g;
      end
      assign sum[i] = bit_pg[i].p ^ carry_in[i];
   end

   assign cout = pref[WIDTH-1].g;

   // A word that only propagates passes the carry-in straight through.
   always_comb begin
      a_r6_full_propagate: assert (!(&prop) || (cout == cin))
         else $error("propagate-only word lost carry-in");
   end

endmodule

// File: rtl/hc_adder.sv
module hc_adder
   import hc_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("hc_adder: WIDTH must be a power of two and at least 4 (R8)");
   end

   hc_pg_t [WIDTH-1:0] bit_pg;
   hc_pg_t [WIDTH-1:0] seed_pg;
   hc_pg_t [WIDTH-1:0] pref;

   hc_prep #(.WIDTH(WIDTH)) u_prep (
      .a       (a),
      .b       (b),
      .cin     (cin),
      .bit_pg  (bit_pg),
      .seed_pg (seed_pg)
   );

   hc_tree #(.WIDTH(WIDTH)) u_tree (
      .leaf (seed_pg),
      .pref (pref)
   );

   hc_post #(.WIDTH(WIDTH)) u_post (
      .bit_pg (bit_pg),
      .pref   (pref),
      .cin    (cin),
      .sum    (sum),
      .cout   (cout)
   );

   // Arithmetic cross-check of the finished result.
   always_comb begin
      a_r1_r2_total: assert ({cout, sum} ==
                             ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("adder total mismatch");
   end

endmodule

// File: tb/test_hc_adder.sv
module test_hc_adder;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [15:0] a16 = '0, b16 = '0, s16;
   logic        c16 = 1'b0, co16;
   logic [7:0]  a8 = '0, b8 = '0, s8;
   logic        c8 = 1'b0, co8;

   hc_adder #(.WIDTH(16)) i_hc_adder (
      .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));

   hc_adder #(.WIDTH(8)) i_hc_adder_w8 (
      .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8));

   task automatic chk16(input logic [15:0] x, input logic [15:0] y,
                        input logic c, input string rq);
      int exp_v;
      int got_v;
      @(posedge clk);
      a16 = x; b16 = y; c16 = c;
      @(negedge clk);
      exp_v = int'(x) + int'(y) + int'(c);
      got_v = int'({co16, s16});
      checks++;
      if (got_v != exp_v) begin
         fails++;
         $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
                  rq, x, y, c, got_v, exp_v);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst = 1'b0;

      // R4: zero inputs, first sample after reset
      @(negedge clk);
      checks++;
      if ({co16, s16} !== 17'h0) begin
         fails++;
         $display("FAIL R4 actual=%h expected=0", {co16, s16});
      end
      chk16(16'h0000, 16'h0000, 1'b0, "R4");

      // R3: carry across the full word
      chk16(16'hFFFF, 16'h0000, 1'b1, "R3");
      chk16(16'h0000, 16'hFFFF, 1'b1, "R3");
      // R5: maximum operands
      chk16(16'hFFFF, 16'hFFFF, 1'b1, "R5");
      chk16(16'hFFFF, 16'hFFFF, 1'b0, "R5");
      // R6: propagate-only words
      chk16(16'hA5C3, 16'h5A3C, 1'b0, "R6");
      chk16(16'hA5C3, 16'h5A3C, 1'b1, "R6");
      chk16(16'h00FF, 16'hFF00, 1'b1, "R6");
      // R7: isolated generate at each bit
      for (int k = 0; k < 16; k++) begin
         chk16(16'(1 << k), 16'(1 << k), 1'b0, "R7");
         chk16(16'(1 << k), 16'(1 << k), 1'b1, "R7");
      end
      // R1 R2: random 16-bit words
      for (int n = 0; n < 3000; n++) begin
         chk16(16'($urandom), 16'($urandom), 1'($urandom), "R1_R2");
      end

      // R8: exhaustive sweep at WIDTH 8
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 256; y++) begin
            for (int c = 0; c < 2; c++) begin
               int exp_v;
               int got_v;
               @(posedge clk);
               a8 = 8'(x); b8 = 8'(y); c8 = 1'(c);
               @(negedge clk);
               exp_v = x + y + c;
               got_v = int'({co8, s8});
               checks++;
               if (got_v != exp_v) begin
                  fails++;
                  $display("FAIL R8 a=%h b=%h cin=%0d actual=%h expected=%h",
                           x, y, c, got_v, exp_v);
               end
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule